// File: doc/BRIEF.md
# Backplane Pulse Transmitter with Strapped Enable

This block turns a stream of transmit bits into pulses on a dc-coupled differential backplane line. An external RS485-style driver buffers the line. Each bit takes one bit cell of `BIT_CYCLES` clocks. A one is sent as a single active-low pulse lasting `PULSE_CYCLES` clocks at the start of its cell. A zero is sent as a cell with no pulse. With the defaults and a 50 MHz clock, this gives a 400 ns cell and a 200 ns pulse.

A frame starts when `txReq` is raised while the block is idle. The transmit-enable output goes active one full bit cell before the first data bit. Bits are then taken one at a time through a valid/ready handshake. After `txReq` is dropped, the enable stays active for one more bit cell and then returns to its inactive level. Pulses only ever appear while the enable is active.

The level that counts as "active" on the enable output is chosen by a strap pin, which is sampled while reset is held. If the pin is pulled to ground and the block runs in backplane mode, the enable is active-high. In every other case the enable is active-low. After reset, the strap pin is driven high only when it was left open. A grounded strap is never driven against.

Top module: `bpl_pulse_tx`

## Requirements
- R1: While `rstN` is low, `pulseN` is high, `bitReady` is low, `strapOe` is low, and `txEn` sits at its inactive level.
- R2: The enable is active-high (`txEn`=1 when active) only when `strapIn` was 0 during reset and `backplaneMode` is 1. Otherwise the enable is active-low (`txEn`=0 when active).
- R3: The clock edge that samples `txReq`=1 in idle makes the enable active. The enable then stays active for `BIT_CYCLES` cycles before `bitReady` first rises.
- R4: `bitReady` is high while waiting for a bit and also in the final cycle of each bit cell, and low in every other cycle. A bit is taken on an edge where `bitValid` and `bitReady` are both 1. Its cell occupies the next `BIT_CYCLES` cycles, so back-to-back bits leave no gap.
- R5: A bit of value 1 drives `pulseN` low for the first `PULSE_CYCLES` cycles of its cell and high for the rest of the cell.
- R6: A bit of value 0 leaves `pulseN` high for its whole cell.
- R7: `pulseN` is low only while the enable is active.
- R8: If `txReq` is 0 and no bit is offered while `bitReady` is high, the enable stays active for `BIT_CYCLES` more cycles and then goes inactive.
- R9: While waiting for a bit with `txReq` high, `bitReady` stays high, the enable stays active and no pulse is sent, however many cycles the wait lasts.
- R10: In idle with `txReq` low, `bitValid` and `bitData` have no effect: `pulseN` stays high, the enable stays inactive and `bitReady` stays low.
- R11: From the second cycle after reset release, `strapOe` equals the value `strapIn` had during reset, and `strapOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; the strap is sampled while it is low |
| backplaneMode | input | 1 | 1 selects backplane mode, where the strapped polarity applies |
| strapIn | input | 1 | Level seen on the strap pin (0 = grounded, 1 = open) |
| txReq | input | 1 | Held high to open and keep a frame; drop it to close the frame |
| bitValid | input | 1 | A transmit bit is offered |
| bitData | input | 1 | Value of the offered bit |
| bitReady | output | 1 | The block can take a bit this cycle |
| pulseN | output | 1 | Active-low data pulse to the line driver |
| txEn | output | 1 | Line driver enable, at the strapped polarity |
| strapOut | output | 1 | Level driven onto the strap pin after reset |
| strapOe | output | 1 | Output enable for the strap pin driver |

## Verification
The assertions assume that `backplaneMode` stays fixed while the block runs. They also assume that `strapIn` holds steady through reset and the first cycle after it, that `PULSE_CYCLES` is smaller than `BIT_CYCLES`, and that a bit offered with `bitValid` keeps its value until it is taken. The bench meets these assumptions as follows. It sets the mode and strap only before asserting reset. It changes `bitValid`, `bitData` and `txReq` only on a falling edge after it has seen `bitReady` high. It closes a frame only at a cycle where `bitReady` is high.

// File: rtl/bpl_pulse_tx_pkg.sv
package bpl_pulse_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SLOT,
    ST_CELL,
    ST_TRAIL
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic loadBit;
    logic cellActive;
    logic enActive;
  } txStrobe_t;

endpackage

// File: rtl/bpl_pulse_tx_ctrl.sv
module bpl_pulse_tx_ctrl
  import bpl_pulse_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txReq,
  input  logic      bitValid,
  input  logic      cntLast,
  output txStrobe_t stb,
  output logic      bitReady
);

  txState_e state;
  txState_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    stb            = '0;
    stb.enActive   = (state != ST_IDLE);
    stb.cellActive = (state == ST_CELL);
    case (state)
      ST_IDLE: begin
        if (txReq) begin
          stateNext    = ST_LEAD;
          stb.cntClear = 1'b1;
        end
      end
      ST_LEAD: begin
        stb.cntRun = 1'b1;
        if (cntLast) begin
          stateNext    = ST_SLOT;
          stb.cntClear = 1'b1;
        end
      end
      ST_SLOT: begin
        if (bitValid) begin
          stateNext    = ST_CELL;
          stb.loadBit  = 1'b1;
          stb.cntClear = 1'b1;
        end else if (!txReq) begin
          stateNext    = ST_TRAIL;
          stb.cntClear = 1'b1;
        end
      end
      ST_CELL: begin
        stb.cntRun = 1'b1;
        if (cntLast) begin
          stb.cntClear = 1'b1;
          if (bitValid) begin
            stateNext   = ST_CELL;
            stb.loadBit = 1'b1;
          end else if (txReq) begin
            stateNext = ST_SLOT;
          end else begin
            stateNext = ST_TRAIL;
          end
        end
      end
      ST_TRAIL: begin
        stb.cntRun = 1'b1;
        if (cntLast) begin
          stateNext    = ST_IDLE;
          stb.cntClear = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign bitReady = (state == ST_SLOT) || ((state == ST_CELL) && cntLast);

  // R4: an accepted bit always opens a cell on the next cycle
  a_r4_accept_opens_cell: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && bitReady) |=> (state == ST_CELL));

  // R10: idle without a request ignores the bit handshake
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !txReq) |=> (state == ST_IDLE && !bitReady));

endmodule

// File: rtl/bpl_pulse_tx_datapath.sv
module bpl_pulse_tx_datapath
  import bpl_pulse_tx_pkg::*;
#(
  parameter int BIT_CYCLES   = 20,
  parameter int PULSE_CYCLES = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t stb,
  input  logic      bitData,
  input  logic      strapIn,
  input  logic      backplaneMode,
  output logic      cntLast,
  output logic      pulseN,
  output logic      txEn,
  output logic      strapOut,
  output logic      strapOe
);

  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST  = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYCLES);

  logic [CW-1:0] cnt;
  logic          bitReg;
  logic          rstHeld;
  logic          strapGnd;
  logic          enHigh;
  logic          pulseOn;

  // cell / lead / trail timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cnt <= '0;
    else if (stb.cntClear)              cnt <= '0;
    else if (stb.cntRun && !cntLast)    cnt <= cnt + 1'b1;
  end

  assign cntLast = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bitReg <= 1'b0;
    else if (stb.loadBit) bitReg <= bitData;
  end

  // reset-window flag: high during reset and the first cycle after it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstHeld <= 1'b1;
    else       rstHeld <= 1'b0;
  end

  // strap capture, frozen once the reset window closes
  always_ff @(posedge clk) begin
    if (rstHeld) strapGnd <= !strapIn;
  end

  assign enHigh   = strapGnd && backplaneMode;
  assign pulseOn  = stb.cellActive && bitReg && (cnt < PULSE_END);
  assign pulseN   = !pulseOn;
  assign txEn     = enHigh ? stb.enActive : !stb.enActive;
  assign strapOut = 1'b1;
  assign strapOe  = !rstHeld && !strapGnd;

  // R7: no pulse outside the enable window
  a_r7_pulse_inside_enable: assert property (@(posedge clk) disable iff (!rstN)
    !pulseN |-> stb.enActive);

  // R5: a pulse only starts right after a bit was loaded
  a_r5_pulse_starts_cell: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseN) |-> $past(stb.loadBit));

  // R6: a zero bit never pulses
  a_r6_zero_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cellActive && !bitReg) |-> pulseN);

  // R11: strap driver stays off while the reset window is open
  a_r11_no_drive_in_reset: assert property (@(posedge clk)
    rstHeld |-> !strapOe);

endmodule

// File: rtl/bpl_pulse_tx.sv
module bpl_pulse_tx
  import bpl_pulse_tx_pkg::*;
#(
  parameter int BIT_CYCLES   = 20,
  parameter int PULSE_CYCLES = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic backplaneMode,
  input  logic strapIn,
  input  logic txReq,
  input  logic bitValid,
  input  logic bitData,
  output logic bitReady,
  output logic pulseN,
  output logic txEn,
  output logic strapOut,
  output logic strapOe
);

  txStrobe_t stb;
  logic      cntLast;

  initial begin
    if (PULSE_CYCLES < 1 || PULSE_CYCLES >= BIT_CYCLES)
      $error("PULSE_CYCLES must lie in 1..BIT_CYCLES-1");
  end

  bpl_pulse_tx_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .txReq    (txReq),
    .bitValid (bitValid),
    .cntLast  (cntLast),
    .stb      (stb),
    .bitReady (bitReady)
  );

  bpl_pulse_tx_datapath #(
    .BIT_CYCLES   (BIT_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .bitData       (bitData),
    .strapIn       (strapIn),
    .backplaneMode (backplaneMode),
    .cntLast       (cntLast),
    .pulseN        (pulseN),
    .txEn          (txEn),
    .strapOut      (strapOut),
    .strapOe       (strapOe)
  );

endmodule

// File: tb/bpl_pulse_tx_tb_top.sv
`timescale 1ns/1ps
module bpl_pulse_tx_tb_top;

  localparam int B  = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic backplaneMode = 1'b0;
  logic strapIn = 1'b1;
  logic txReq = 1'b0;
  logic bitValid = 1'b0;
  logic bitData = 1'b0;
  logic bitReady, pulseN, txEn, strapOut, strapOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bpl_pulse_tx #(.BIT_CYCLES(B), .PULSE_CYCLES(PW)) dut_i (
    .clk(clk), .rstN(rstN), .backplaneMode(backplaneMode), .strapIn(strapIn),
    .txReq(txReq), .bitValid(bitValid), .bitData(bitData), .bitReady(bitReady),
    .pulseN(pulseN), .txEn(txEn), .strapOut(strapOut), .strapOe(strapOe)
  );

  task automatic check(input string req, input logic got, input logic exp, input int s);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s at sample %0d: actual %b expected %b", req, s, got, exp);
    end
  endtask

  task automatic do_reset(input bit strap, input bit mode);
    bit enHigh;
    enHigh = mode && !strap;
    @(negedge clk);
    strapIn = strap; backplaneMode = mode;
    txReq = 1'b0; bitValid = 1'b0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pulseN", pulseN, 1'b1, -1);
    check("R1 bitReady", bitReady, 1'b0, -1);
    check("R1 strapOe", strapOe, 1'b0, -1);
    check("R1/R2 txEn inactive", txEn, enHigh ? 1'b0 : 1'b1, -1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 strapOe", strapOe, strap, -2);
    check("R11 strapOut", strapOut, 1'b1, -2);
  endtask

  // R10: handshake offered while idle and not requested
  task automatic idle_check(input bit enHigh);
    @(negedge clk);
    bitValid = 1'b1; bitData = 1'b1;
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      check("R10 pulseN", pulseN, 1'b1, s);
      check("R10 txEn", txEn, enHigh ? 1'b0 : 1'b1, s);
      check("R10 bitReady", bitReady, 1'b0, s);
    end
    bitValid = 1'b0;
  endtask

  // bits sent LSB first; g idle slot cycles before each bit
  task automatic run_frame(input int pat, input int nb, input int g, input bit enHigh);
    int p, e, idx, gapCnt, d, d2, bi, c;
    bit expEn, expRdy, expPulse, inCell;
    string tagEn, tagPl;
    p = B + g;
    e = nb * p + B;
    @(negedge clk);
    txReq = 1'b1; bitValid = 1'b0;
    idx = 0; gapCnt = g;
    for (int s = 0; s <= e + B + 3; s++) begin
      @(negedge clk);
      d = s - B;
      expEn = (s <= e + B);
      expRdy = (s >= B) && (s <= e) && ((d % p) <= g);
      d2 = d - g - 1;
      inCell = 1'b0; bi = 0; c = 0;
      if (d2 >= 0) begin
        bi = d2 / p; c = d2 % p;
        inCell = (bi < nb) && (c < B);
      end
      expPulse = inCell && pat[bi] && (c < PW);
      tagEn = (s < B) ? "R3 lead enable" : ((s > e) ? "R8 trail enable" : "R9 enable");
      tagPl = !inCell ? "R7/R9 no pulse" : (pat[bi] ? "R5 one pulse" : "R6 zero quiet");
      check(tagEn, txEn, enHigh ? expEn : !expEn, s);
      check(g > 0 ? "R9 bitReady" : "R4 bitReady", bitReady, expRdy, s);
      check(tagPl, pulseN, !expPulse, s);
      if (bitReady) begin
        if (idx == nb) begin
          txReq = 1'b0; bitValid = 1'b0;
        end else if (gapCnt > 0) begin
          gapCnt--; bitValid = 1'b0;
        end else begin
          bitValid = 1'b1; bitData = pat[idx];
          idx++; gapCnt = g;
        end
      end
    end
    bitValid = 1'b0;
  endtask

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit strap, mode, enHigh;
      strap = cfg[0]; mode = cfg[1];
      enHigh = mode && !strap;
      do_reset(strap, mode);
      idle_check(enHigh);
      for (int g = 0; g <= 2; g += 2)
        for (int pat = 0; pat < 16; pat++)
          run_frame(pat, 4, g, enHigh);
      run_frame(1, 1, 0, enHigh);
      run_frame(6'b101101, 6, 1, enHigh);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog R4: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule